// File: doc/BRIEF.md
# Encoder Velocity Capture Timer

This block measures encoder speed over windows of fixed length. A down-counting timer marks out each window and reloads itself when it runs out. A pulse counter counts the encoder strobes that arrive while the window is open. When the timer reaches zero, three things happen together: the pulse total is copied into a capture register, the counter starts again for the next window, and the timer reloads.

Every captured total is compared once against a programmable threshold. A single-cycle flag marks each timer expiry. A second single-cycle flag, raised together with it, shows that the captured total fell below the threshold. This lets a controller detect a stalled or slow axis without polling. The live timer value, the live pulse count and the last capture can all be read directly as outputs. A clear command discards the measurement in progress and starts a fresh window.

Top module: `enc_vel_capture`

## Requirements
- R1: While reset is asserted, the timer, live count and capture outputs are zero, and both flags are low.
- R2: When no clear is requested, a nonzero timer falls by exactly one per cycle. A zero timer loads the value present on `reload_i` during that zero cycle. This gives a steady window period of reload+1 cycles. Changing `reload_i` in the middle of a window has no effect until the next load.
- R3: In the cycle after the timer was zero, `capture_o` holds the pulse total of the window that just ended, and `timer_flag_o` is high for exactly that one cycle. At all other times the capture holds its value and the flag is low.
- R4: A strobe that arrives in the cycle where the timer is zero is not part of the captured total. It becomes the first count of the new window, so the live count is 1 right after the capture. Without such a strobe it is 0.
- R5: `slow_flag_o` is high only in the flag cycle of R3, and only when the captured total is strictly less than the `compare_i` value present in the expiry cycle. Changing `compare_i` between captures never raises it.
- R6: A cycle with `vel_clear_i` high makes the next cycle show live count 0, capture 0, the timer equal to `reload_i`, and both flags low. This holds even if the timer was zero or a strobe arrived in that cycle.
- R7: The live count stops at 2^CNT_W-1 and does not wrap around, so a window with more strobes than that captures 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_pulse_i | input | 1 | Encoder pulse strobe, one count per high cycle |
| reload_i | input | TIMER_W | Window length minus one, loaded at each expiry or clear |
| compare_i | input | CNT_W | Low-speed threshold for the captured total |
| vel_clear_i | input | 1 | Clear the measurement and restart the window |
| timer_o | output | TIMER_W | Live window timer |
| count_o | output | CNT_W | Live pulse count of the open window |
| capture_o | output | CNT_W | Pulse total of the last completed window |
| timer_flag_o | output | 1 | One-cycle strobe on each timer expiry |
| slow_flag_o | output | 1 | One-cycle strobe when the capture is below the threshold |

## Verification
The bench aims at the window boundary. A strobe in the expiry cycle must open the next window. A design that gives it to the closing window captures one too many, and the next capture comes out one short. Equality with the threshold must leave the slow flag low, which catches a less-or-equal compare. A threshold raised in the middle of a window must not raise the flag early, which exposes a continuous compare. A new reload value must wait for the expiry, which exposes a timer that follows `reload_i` directly. A clear is issued in the same cycle as an expiry, and a clear is also issued while a strobe arrives. Together these show whether the clear really has priority: a design that gets the priority wrong leaks a stale capture or a flag. An overlong window shows whether the counter wraps to a small total instead of stopping at its maximum.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    localparam int DEF_TIMER_W = 32;
    localparam int DEF_CNT_W   = 16;

    // Next-value selection for the window pulse counter.
    typedef enum logic [1:0] {
        CNT_HOLD    = 2'd0,
        CNT_STEP    = 2'd1,
        CNT_RESTART = 2'd2,
        CNT_ZERO    = 2'd3
    } cnt_op_e;

endpackage

// File: rtl/vcap_window_timer.sv
module vcap_window_timer #(
    parameter int TW = vcap_pkg::DEF_TIMER_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic [TW-1:0] reload_i,
    output logic [TW-1:0] timer_o,
    output logic          expire_o
);

    typedef struct packed {
        logic [TW-1:0] timer;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       at_zero;

    assign at_zero = (st_q.timer == '0);

    always_comb begin
        st_d = st_q;
        if (clear_i || at_zero) begin
            st_d.timer = reload_i;
        end else begin
            st_d.timer = st_q.timer - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign timer_o  = st_q.timer;
    assign expire_o = at_zero && !clear_i;

endmodule

// File: rtl/vcap_pulse_count.sv
module vcap_pulse_count #(
    parameter int CW = vcap_pkg::DEF_CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          restart_i,
    input  logic          pulse_i,
    output logic [CW-1:0] count_o
);

    import vcap_pkg::*;

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    cnt_op_e    op;

    always_comb begin
        if (clear_i) begin
            op = CNT_ZERO;
        end else if (restart_i) begin
            op = CNT_RESTART;
        end else if (pulse_i) begin
            op = CNT_STEP;
        end else begin
            op = CNT_HOLD;
        end
    end

    always_comb begin
        st_d = st_q;
        case (op)
            CNT_ZERO:    st_d.count = '0;
            CNT_RESTART: st_d.count = CW'(pulse_i);
            CNT_STEP:    st_d.count = (st_q.count == CNT_MAX) ? CNT_MAX
                                                              : st_q.count + CW'(1);
            default:     st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

endmodule

// File: rtl/vcap_capture.sv
module vcap_capture #(
    parameter int CW = vcap_pkg::DEF_CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          expire_i,
    input  logic [CW-1:0] count_i,
    input  logic [CW-1:0] compare_i,
    output logic [CW-1:0] capture_o,
    output logic          timer_flag_o,
    output logic          slow_flag_o
);

    typedef struct packed {
        logic [CW-1:0] capture;
        logic          tflag;
        logic          sflag;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.tflag = 1'b0;
        st_d.sflag = 1'b0;
        if (clear_i) begin
            st_d.capture = '0;
        end else if (expire_i) begin
            st_d.capture = count_i;
            st_d.tflag   = 1'b1;
            st_d.sflag   = (count_i < compare_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign capture_o    = st_q.capture;
    assign timer_flag_o = st_q.tflag;
    assign slow_flag_o  = st_q.sflag;

endmodule

// File: rtl/enc_vel_capture.sv
module enc_vel_capture #(
    parameter int TIMER_W = vcap_pkg::DEF_TIMER_W,
    parameter int CNT_W   = vcap_pkg::DEF_CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enc_pulse_i,
    input  logic [TIMER_W-1:0] reload_i,
    input  logic [CNT_W-1:0]   compare_i,
    input  logic               vel_clear_i,
    output logic [TIMER_W-1:0] timer_o,
    output logic [CNT_W-1:0]   count_o,
    output logic [CNT_W-1:0]   capture_o,
    output logic               timer_flag_o,
    output logic               slow_flag_o
);

    logic expire;

    vcap_window_timer #(.TW(TIMER_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (vel_clear_i),
        .reload_i (reload_i),
        .timer_o  (timer_o),
        .expire_o (expire)
    );

    vcap_pulse_count #(.CW(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (vel_clear_i),
        .restart_i (expire),
        .pulse_i   (enc_pulse_i),
        .count_o   (count_o)
    );

    vcap_capture #(.CW(CNT_W)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (vel_clear_i),
        .expire_i     (expire),
        .count_i      (count_o),
        .compare_i    (compare_i),
        .capture_o    (capture_o),
        .timer_flag_o (timer_flag_o),
        .slow_flag_o  (slow_flag_o)
    );

endmodule

// File: rtl/enc_vel_capture_chk.sv
module enc_vel_capture_chk #(
    parameter int TW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pulse,
    input logic [TW-1:0] reload,
    input logic          clear,
    input logic [TW-1:0] timer,
    input logic [CW-1:0] count,
    input logic [CW-1:0] capture,
    input logic          tflag,
    input logic          sflag
);

    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && timer != '0) |=> (timer == $past(timer) - TW'(1)));

    a_r2_reload_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && timer == '0) |=> (timer == $past(reload)));

    a_r3_flag_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && timer == '0) |=> tflag);

    a_r3_no_flag_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (clear || timer != '0) |=> !tflag);

    a_r3_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && timer != '0) |=> $stable(capture));

    a_r4_restart_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && timer == '0) |=> (count == CW'($past(pulse))));

    a_r5_slow_with_timer: assert property (@(posedge clk) disable iff (!rst_n)
        sflag |-> tflag);

    a_r6_clear_effect: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && capture == '0 && !tflag && !sflag
                   && timer == $past(reload)));

    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && timer != '0 && count == CMAX) |=> (count == CMAX));

endmodule

bind enc_vel_capture enc_vel_capture_chk #(.TW(TIMER_W), .CW(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse   (enc_pulse_i),
    .reload  (reload_i),
    .clear   (vel_clear_i),
    .timer   (timer_o),
    .count   (count_o),
    .capture (capture_o),
    .tflag   (timer_flag_o),
    .sflag   (slow_flag_o)
);

// File: tb/enc_vel_capture_bench.sv
`timescale 1ns/1ps
module enc_vel_capture_bench;

    localparam int TW = 16;
    localparam int CW = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enc_pulse = 1'b0;
    logic [TW-1:0] reload = '0;
    logic [CW-1:0] compare = '0;
    logic          vel_clear = 1'b0;
    logic [TW-1:0] timer;
    logic [CW-1:0] count;
    logic [CW-1:0] capture;
    logic          tflag;
    logic          sflag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    enc_vel_capture #(.TIMER_W(TW), .CNT_W(CW)) u_enc_vel_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .enc_pulse_i  (enc_pulse),
        .reload_i     (reload),
        .compare_i    (compare),
        .vel_clear_i  (vel_clear),
        .timer_o      (timer),
        .count_o      (count),
        .capture_o    (capture),
        .timer_flag_o (tflag),
        .slow_flag_o  (sflag)
    );

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R1: values while reset is held
    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", "timer in reset", int'(timer), 0);
        check("R1", "count in reset", int'(count), 0);
        check("R1", "capture in reset", int'(capture), 0);
        check("R1", "flags in reset", int'({tflag, sflag}), 0);
        vel_clear = 1'b1;
        rst_n     = 1'b1;
    endtask

    // One complete window started by a clear; np strobes at its start,
    // strobe 'extra' in the expiry cycle.
    task automatic run_window(input int r, input int np, input bit extra, input int cmp);
        int exp_cap;
        exp_cap   = (np > CMAX) ? CMAX : np;
        reload    = TW'(r);
        compare   = CW'(cmp);
        vel_clear = 1'b1;
        @(negedge clk);
        vel_clear = 1'b0;
        check("R6", "timer after clear", int'(timer), r);
        check("R6", "count after clear", int'(count), 0);
        check("R6", "capture after clear", int'(capture), 0);
        check("R6", "flags after clear", int'({tflag, sflag}), 0);
        for (int i = 0; i < r; i++) begin
            enc_pulse = (i < np);
            @(negedge clk);
            if (i == 0) check("R2", "timer one step", int'(timer), r - 1);
        end
        enc_pulse = extra;
        check("R2", "timer at zero", int'(timer), 0);
        check("R7", "live count at window end", int'(count), exp_cap);
        @(negedge clk);
        enc_pulse = 1'b0;
        check("R3", "capture", int'(capture), exp_cap);
        check("R3", "timer flag", int'(tflag), 1);
        check("R5", "slow flag", int'(sflag), int'(exp_cap < cmp));
        check("R4", "count after capture", int'(count), int'(extra));
        check("R2", "timer reloaded", int'(timer), r);
        @(negedge clk);
        check("R3", "timer flag one cycle", int'(tflag), 0);
        check("R5", "slow flag one cycle", int'(sflag), 0);
    endtask

    // Window following run_window: only the carried strobe is in it.
    task automatic t_next_window(input int r, input bit extra);
        repeat (r - 1) @(negedge clk);
        check("R2", "timer zero after r+1 cycles", int'(timer), 0);
        @(negedge clk);
        check("R4", "carried strobe captured", int'(capture), int'(extra));
        check("R3", "second expiry flag", int'(tflag), 1);
    endtask

    // Clear arriving with a strobe in the middle of a window.
    task automatic t_clear_mid();
        reload    = 20;
        vel_clear = 1'b1;
        @(negedge clk);
        vel_clear = 1'b0;
        enc_pulse = 1'b1;
        repeat (5) @(negedge clk);
        check("R7", "counting mid window", int'(count), 5);
        vel_clear = 1'b1;
        @(negedge clk);
        vel_clear = 1'b0;
        enc_pulse = 1'b0;
        check("R6", "clear with strobe count", int'(count), 0);
        check("R6", "clear mid timer", int'(timer), 20);
    endtask

    // Clear in the expiry cycle: no capture, no flag.
    task automatic t_clear_at_expiry();
        reload    = 4;
        vel_clear = 1'b1;
        @(negedge clk);
        vel_clear = 1'b0;
        enc_pulse = 1'b1;
        repeat (2) @(negedge clk);
        enc_pulse = 1'b0;
        repeat (2) @(negedge clk);
        check("R2", "timer zero before clear", int'(timer), 0);
        reload    = 6;
        vel_clear = 1'b1;
        @(negedge clk);
        vel_clear = 1'b0;
        check("R6", "no flag on cleared expiry", int'(tflag), 0);
        check("R6", "no capture on cleared expiry", int'(capture), 0);
        check("R6", "timer from new reload", int'(timer), 6);
    endtask

    // Compare and reload changed mid window take effect only at expiry.
    task automatic t_midchange();
        int flag_seen;
        flag_seen = 0;
        reload    = 6;
        compare   = 0;
        vel_clear = 1'b1;
        @(negedge clk);
        vel_clear = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (i == 2) begin
                compare = 10;
                reload  = 3;
            end
            @(negedge clk);
            if (tflag || sflag) flag_seen++;
            if (i == 3) check("R2", "reload change ignored mid window", int'(timer), 2);
        end
        check("R5", "no flag while compare raised", flag_seen, 0);
        @(negedge clk);
        check("R5", "slow flag at capture", int'(sflag), 1);
        check("R2", "new reload used at expiry", int'(timer), 3);
    endtask

    initial begin
        t_reset();
        run_window(9, 4, 1'b1, 5);
        t_next_window(9, 1'b1);
        run_window(7, 3, 1'b0, 3);
        run_window(5, 0, 1'b0, 1);
        run_window(300, 280, 1'b0, 0);
        t_clear_mid();
        t_clear_at_expiry();
        t_midchange();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule